// File: doc/BRIEF.md
# Vector Register Move and Swizzle Unit

This block holds the sixteen vector registers of a small vector core and carries out the two register-to-register operations of its instruction set: a lane-masked copy from one register to another, and a rearrangement of one register's own lanes in place. Every register holds four 16-bit lanes named X, Y, Z and W, with X in the least significant bits. Indices 0 to 7 name the constant registers c0 to c7, indices 8 to 14 name the general registers r0 to r6, and index 15 names the instruction register ri. The X lane of ri is the program counter.

A decoded 16-bit instruction word arrives with a valid strobe and takes effect at the next clock edge. Ordinary instructions cannot write the constant registers. A separate strobe loads all eight of them at once from a wide parallel port, which the core uses at start-up. A combinational read port lets the rest of the core, or a bench, see any register.

Top module: `vmu_core`

## Requirements
- R1: While rst_n is low at a clock edge, every register, and so pc, becomes zero.
- R2: When const_load is high at a clock edge, register k (k = 0..7) takes const_data[64k+63:64k], with lane X in the lowest 16 bits of that slice and lane W in the highest.
- R3: No instruction changes c0..c7. A move or swizzle whose destination index is 0..7 changes no register other than the pc step of R7.
- R4: Fields are instr[15:12] destination, instr[11:8] source, instr[7:4] mask, instr[3:0] opcode. Opcode 0x4 (move) copies each source lane into the same destination lane, except that a set mask bit i (bit 0 = X, 1 = Y, 2 = Z, 3 = W) leaves destination lane i unchanged.
- R5: Opcode 0x5 (swizzle) sets destination lane X, Y, Z, W to the old destination lane chosen by the 2-bit selectors instr[5:4], instr[7:6], instr[9:8], instr[11:10] respectively (0 = X ... 3 = W), so 0xF905 turns ri into (x, x, y, z) of its old value.
- R6: All lanes written by one instruction change at the same clock edge, and every lane read by that instruction is the value from before that edge, including when source and destination are the same register.
- R7: pc is lane X of ri. Each accepted instruction adds 1 to pc, wrapping from 0xFFFF to 0, unless that instruction writes ri lane X (a move to ri with mask bit 0 clear, or any swizzle of ri), in which case pc takes the written value.
- R8: An instruction with any opcode other than 0x4 or 0x5 changes no register except for the pc step of R7. With instr_valid low, no instruction takes effect and pc holds.
- R9: When const_load and an instruction arrive in the same cycle, the instruction reads the constant values from before the load, and the load and the instruction's writes both take effect at that edge.
- R10: rd_data shows, without a clock, the full register selected by rd_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction word is to be executed at this edge |
| instr | input | 16 | Decoded instruction word |
| const_load | input | 1 | Load all constant registers at this edge |
| const_data | input | 512 | Eight packed 64-bit constant register values |
| rd_sel | input | 4 | Register index for the read port |
| rd_data | output | 64 | Contents of the selected register |
| pc | output | 16 | Lane X of the instruction register |

## Verification
Two things can land on the same edge. A bulk constant load can arrive together with a move that reads a constant register, and the pc step can meet an instruction that writes ri. The bench issues a load carrying new values in the cycle where a move copies c3 into r0. It then expects r0 to hold the old c3 and c3 to hold the new value. Across the sweeps over all destination, source and mask values, the bench counts on ri.x being either stepped or overwritten, never both, with the choice fixed by the mask bit for X. It also drives pc to 0xFFFF and checks that it wraps to zero.

// File: rtl/vmu_pkg.sv
`timescale 1ns/1ps
// Shared constants and the instruction field layout of the vector move unit.
// Assumes a 16-bit word split into four 4-bit fields.
package vmu_pkg;
    localparam int LANE_W      = 16;
    localparam int LANES       = 4;
    localparam int SEL_W       = $clog2(LANES);
    localparam int VEC_W       = LANE_W * LANES;
    localparam int REG_COUNT   = 16;
    localparam int IDX_W       = $clog2(REG_COUNT);
    localparam int CONST_COUNT = 8;
    localparam int RI_IDX      = REG_COUNT - 1;

    localparam logic [3:0] OP_MOVE = 4'h4;
    localparam logic [3:0] OP_SWZ  = 4'h5;

    typedef struct packed {
        logic [3:0] dst;
        logic [3:0] src;
        logic [3:0] extra;
        logic [3:0] op;
    } instr_t;
endpackage

// File: rtl/vmu_decode.sv
`timescale 1ns/1ps
// Turns an instruction word into a read index, a lane write mask and
// per-lane source selectors. Assumes only move and swizzle write registers
// and that destinations below CONST_COUNT are read-only.
module vmu_decode
    import vmu_pkg::*;
(
    input  logic                   instr_valid,
    input  logic [15:0]            instr,
    output logic [IDX_W-1:0]       rd_idx,
    output logic [IDX_W-1:0]       wr_idx,
    output logic                   wr_en,
    output logic [LANES-1:0]       wr_mask,
    output logic [LANES*SEL_W-1:0] lane_sel,
    output logic                   pc_hold
);
    instr_t f;
    logic   dst_writable;

    assign f            = instr_t'(instr);
    assign dst_writable = (int'(f.dst) >= CONST_COUNT);
    assign wr_idx       = f.dst;

    // Select operand register, write lanes and lane routing per opcode.
    always_comb begin
        rd_idx  = f.src;
        wr_en   = 1'b0;
        wr_mask = '0;
        for (int l = 0; l < LANES; l++) lane_sel[l*SEL_W +: SEL_W] = SEL_W'(l);
        case (f.op)
            OP_MOVE: begin
                wr_en   = instr_valid && dst_writable;
                wr_mask = ~f.extra;
            end
            OP_SWZ: begin
                rd_idx   = f.dst;
                wr_en    = instr_valid && dst_writable;
                wr_mask  = '1;
                lane_sel = {f.src, f.extra};
            end
            default: ;
        endcase
    end

    // The program counter is overwritten instead of stepped when ri.x is written.
    assign pc_hold = wr_en && (int'(f.dst) == RI_IDX) && wr_mask[0];
endmodule

// File: rtl/vmu_lane_xbar.sv
`timescale 1ns/1ps
// Routes any lane of the operand vector to each output lane.
// Assumes selectors are packed lane 0 first, SEL_W bits each.
module vmu_lane_xbar
    import vmu_pkg::*;
(
    input  logic [VEC_W-1:0]       in_vec,
    input  logic [LANES*SEL_W-1:0] lane_sel,
    output logic [VEC_W-1:0]       out_vec
);
    logic [LANE_W-1:0] lane_in [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Split input and pick the selected lane for output lane l.
        assign lane_in[l] = in_vec[l*LANE_W +: LANE_W];
        assign out_vec[l*LANE_W +: LANE_W] = lane_in[lane_sel[l*SEL_W +: SEL_W]];
    end
endmodule

// File: rtl/vmu_regfile.sv
`timescale 1ns/1ps
// Vector register storage: constant registers loaded only in bulk, writable
// registers updated per lane, and a program counter step on lane X of the
// last register. Assumes wr_en never targets a constant register and that
// pc_inc is low whenever lane X of the last register is written.
module vmu_regfile
    import vmu_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         const_load,
    input  logic [CONST_COUNT*VEC_W-1:0] const_data,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [LANES-1:0]             wr_mask,
    input  logic [VEC_W-1:0]             wr_vec,
    input  logic                         pc_inc,
    input  logic [IDX_W-1:0]             rd_a_idx,
    input  logic [IDX_W-1:0]             rd_b_idx,
    output logic [VEC_W-1:0]             rd_a_vec,
    output logic [VEC_W-1:0]             rd_b_vec,
    output logic [LANE_W-1:0]            pc
);
    logic [VEC_W-1:0] regs_w [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        logic [VEC_W-1:0] q;
        if (g < CONST_COUNT) begin : g_const
            // Constant register: cleared by reset, loaded only by the bulk port.
            always_ff @(posedge clk) begin
                if (!rst_n)          q <= '0;
                else if (const_load) q <= const_data[g*VEC_W +: VEC_W];
            end
        end else begin : g_var
            // Writable register: per-lane writes, plus pc step on the last one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    for (int l = 0; l < LANES; l++) begin
                        if (wr_en && (wr_idx == IDX_W'(g)) && wr_mask[l])
                            q[l*LANE_W +: LANE_W] <= wr_vec[l*LANE_W +: LANE_W];
                        else if ((g == RI_IDX) && (l == 0) && pc_inc)
                            q[LANE_W-1:0] <= q[LANE_W-1:0] + 1'b1;
                    end
                end
            end
        end
        assign regs_w[g] = q;
    end

    assign rd_a_vec = regs_w[rd_a_idx];
    assign rd_b_vec = regs_w[rd_b_idx];
    assign pc       = regs_w[RI_IDX][LANE_W-1:0];
endmodule

// File: rtl/vmu_core.sv
`timescale 1ns/1ps
// Vector register move and swizzle unit: decodes one instruction per valid
// cycle, reads one operand register, routes its lanes and writes the masked
// result back at the same edge. Assumes instructions other than move and
// swizzle are handled elsewhere and only step the program counter here.
module vmu_core
    import vmu_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         instr_valid,
    input  logic [15:0]                  instr,
    input  logic                         const_load,
    input  logic [CONST_COUNT*VEC_W-1:0] const_data,
    input  logic [IDX_W-1:0]             rd_sel,
    output logic [VEC_W-1:0]             rd_data,
    output logic [LANE_W-1:0]            pc
);
    logic [IDX_W-1:0]       op_idx;
    logic [IDX_W-1:0]       wr_idx;
    logic                   wr_en;
    logic [LANES-1:0]       wr_mask;
    logic [LANES*SEL_W-1:0] lane_sel;
    logic                   pc_hold;
    logic [VEC_W-1:0]       op_vec;
    logic [VEC_W-1:0]       wr_vec;
    logic                   pc_inc;

    vmu_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .rd_idx      (op_idx),
        .wr_idx      (wr_idx),
        .wr_en       (wr_en),
        .wr_mask     (wr_mask),
        .lane_sel    (lane_sel),
        .pc_hold     (pc_hold)
    );

    vmu_lane_xbar u_xbar (
        .in_vec   (op_vec),
        .lane_sel (lane_sel),
        .out_vec  (wr_vec)
    );

    // Every accepted instruction steps pc unless it writes ri.x itself.
    assign pc_inc = instr_valid && !pc_hold;

    vmu_regfile u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .const_load (const_load),
        .const_data (const_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_mask    (wr_mask),
        .wr_vec     (wr_vec),
        .pc_inc     (pc_inc),
        .rd_a_idx   (op_idx),
        .rd_b_idx   (rd_sel),
        .rd_a_vec   (op_vec),
        .rd_b_vec   (rd_data),
        .pc         (pc)
    );
endmodule

// File: rtl/vmu_core_chk.sv
`timescale 1ns/1ps
// Property checker for vmu_core, attached by bind. Observes ports and the
// operand vector read by the current instruction.
module vmu_core_chk
    import vmu_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         instr_valid,
    input logic [15:0]                  instr,
    input logic                         const_load,
    input logic [CONST_COUNT*VEC_W-1:0] const_data,
    input logic [IDX_W-1:0]             rd_sel,
    input logic [VEC_W-1:0]             rd_data,
    input logic [LANE_W-1:0]            pc,
    input logic [VEC_W-1:0]             op_vec
);
    logic to_ri, mv_rix, swz_ri, rd_const;
    assign to_ri    = (instr[15:12] == 4'hF);
    assign mv_rix   = instr_valid && to_ri && (instr[3:0] == 4'h4) && !instr[4];
    assign swz_ri   = instr_valid && to_ri && (instr[3:0] == 4'h5);
    assign rd_const = (int'(rd_sel) < CONST_COUNT);

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !mv_rix && !swz_ri) |=> (pc == LANE_W'($past(pc) + 1'b1)));

    // R8
    pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc));

    // R4
    pc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_rix |=> (pc == $past(op_vec[LANE_W-1:0])));

    // R5
    pc_swz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swz_ri |=> (pc == $past(op_vec[instr[5:4]*LANE_W +: LANE_W])));

    // R3
    const_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!const_load && rd_const) |=> ((rd_sel != $past(rd_sel)) || (rd_data == $past(rd_data))));

    // R2
    const_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (const_load && rd_const) |=> ((rd_sel != $past(rd_sel)) ||
            (rd_data == $past(const_data[rd_sel[$clog2(CONST_COUNT)-1:0]*VEC_W +: VEC_W]))));
endmodule

bind vmu_core vmu_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .const_load  (const_load),
    .const_data  (const_data),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .pc          (pc),
    .op_vec      (op_vec)
);

// File: tb/test_vmu_core.sv
`timescale 1ns/1ps
module test_vmu_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [15:0]  instr = '0;
    logic         const_load = 1'b0;
    logic [511:0] const_data = '0;
    logic [3:0]   rd_sel = '0;
    logic [63:0]  rd_data;
    logic [15:0]  pc;

    int total = 0;
    int bad = 0;
    bit reported = 0;
    logic [63:0] exp_r [16];

    vmu_core i_vmu_core (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
        .const_load (const_load), .const_data (const_data),
        .rd_sel (rd_sel), .rd_data (rd_data), .pc (pc)
    );

    always #2 clk = ~clk;

    task automatic check_reg(input int idx, input string req);
        rd_sel = 4'(idx);
        #0.25;
        total++;
        if (rd_data !== exp_r[idx]) begin
            bad++;
            $display("FAIL %s reg %0d actual=%h expected=%h", req, idx, rd_data, exp_r[idx]);
        end
    endtask

    task automatic check_pc(input string req);
        total++;
        if (pc !== exp_r[15][15:0]) begin
            bad++;
            $display("FAIL %s pc actual=%h expected=%h", req, pc, exp_r[15][15:0]);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) check_reg(i, req);
        check_pc(req);
    endtask

    // Expected effect of one instruction, taken from R3..R8.
    task automatic model_instr(input logic [15:0] w);
        logic [63:0] old [16];
        logic [3:0] d, s, e, o;
        logic [7:0] sel;
        bit rix;
        d = w[15:12]; s = w[11:8]; e = w[7:4]; o = w[3:0];
        sel = {s, e};
        rix = 0;
        for (int i = 0; i < 16; i++) old[i] = exp_r[i];
        if (o == 4'h4 && d >= 8) begin
            for (int l = 0; l < 4; l++)
                if (!e[l]) begin
                    exp_r[d][l*16 +: 16] = old[s][l*16 +: 16];
                    if (l == 0 && d == 15) rix = 1;
                end
        end else if (o == 4'h5 && d >= 8) begin
            for (int l = 0; l < 4; l++)
                exp_r[d][l*16 +: 16] = old[d][sel[l*2 +: 2]*16 +: 16];
            if (d == 15) rix = 1;
        end
        if (!rix) exp_r[15][15:0] = exp_r[15][15:0] + 16'd1;
    endtask

    task automatic exec(input logic [15:0] w, input bit ld, input logic [511:0] cd);
        @(negedge clk);
        instr = w; instr_valid = 1'b1; const_load = ld; const_data = cd;
        @(negedge clk);
        instr_valid = 1'b0; const_load = 1'b0;
        model_instr(w);
        if (ld) for (int k = 0; k < 8; k++) exp_r[k] = cd[k*64 +: 64];
    endtask

    task automatic bulk_load(input logic [511:0] cd);
        @(negedge clk);
        const_load = 1'b1; const_data = cd;
        @(negedge clk);
        const_load = 1'b0;
        for (int k = 0; k < 8; k++) exp_r[k] = cd[k*64 +: 64];
    endtask

    task automatic refill();
        for (int i = 8; i < 16; i++) exec({4'(i), 4'(i - 8), 4'h0, 4'h4}, 0, const_data);
    endtask

    function automatic logic [511:0] make_consts(input logic [7:0] salt);
        logic [511:0] v;
        for (int k = 0; k < 8; k++)
            for (int l = 0; l < 4; l++)
                v[(k*4 + l)*16 +: 16] = {4'(k), 4'(l), 8'(salt + 8'(k*29 + l*7))};
        return v;
    endfunction

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        logic [511:0] cd;
        for (int i = 0; i < 16; i++) exp_r[i] = '0;
        // R1: reset clears everything
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2: bulk load of the constant registers, R10 read port
        cd = make_consts(8'h3C);
        bulk_load(cd);
        check_all("R2_R10");

        // R4 / R3 / R6: every destination, source and mask for move
        for (int d = 0; d < 16; d++) begin
            refill();
            for (int s = 0; s < 16; s++)
                for (int m = 0; m < 16; m++) begin
                    exec({4'(d), 4'(s), 4'(m), 4'h4}, 0, const_data);
                    check_reg(d, (d < 8) ? "R3" : "R4_R6");
                    check_pc("R7");
                end
            check_all("R4");
        end

        // R5 / R3: every destination and selector set for swizzle
        for (int d = 0; d < 16; d++)
            for (int sel = 0; sel < 256; sel++) begin
                if (d >= 8) exec({4'(d), 4'(d - 8), 4'h0, 4'h4}, 0, const_data);
                exec({4'(d), 4'(sel >> 4), 4'(sel & 15), 4'h5}, 0, const_data);
                check_reg(d, (d < 8) ? "R3" : "R5_R6");
                check_pc("R7");
            end
        check_all("R5");

        // R5: the stack-push encoding on known values
        exec(16'hF004, 0, const_data);
        exec(16'hF905, 0, const_data);
        total++;
        rd_sel = 4'hF;
        #0.25;
        if (rd_data !== {const_data[47:32], const_data[31:16], const_data[15:0], const_data[15:0]}) begin
            bad++;
            $display("FAIL R5 push actual=%h expected=%h", rd_data,
                     {const_data[47:32], const_data[31:16], const_data[15:0], const_data[15:0]});
        end

        // R8: other opcodes only step pc
        for (int o = 0; o < 16; o++)
            if (o != 4 && o != 5) begin
                exec({4'hA, 4'h3, 4'h0, 4'(o)}, 0, const_data);
                exec({4'hF, 4'h2, 4'h0, 4'(o)}, 0, const_data);
                check_all("R8");
            end
        // R8: idle cycles hold pc
        repeat (5) @(negedge clk);
        check_all("R8_idle");

        // R9: bulk load together with a move that reads c3
        cd = make_consts(8'h91);
        exec(16'h8304, 1, cd);
        check_reg(8, "R9");
        check_reg(3, "R9");
        check_all("R9");

        // R7: pc wrap from 0xFFFF to 0
        cd = const_data;
        cd[7*64 +: 16] = 16'hFFFF;
        bulk_load(cd);
        exec(16'hF7E4, 0, const_data);
        check_pc("R7_load");
        exec(16'h0000, 0, const_data);
        check_pc("R7_wrap");
        total++;
        if (pc !== 16'h0000) begin
            bad++;
            $display("FAIL R7 wrap actual=%h expected=0000", pc);
        end

        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule